// File: doc/BRIEF.md
# CCD Pixel Region Tagger and Dark-Level Averager

This block sits on the digitised output stream of a full-frame colour CCD. It takes a pixel strobe, a line marker, a frame marker and a sample on each accepted pixel. It keeps its own row and column position and gives every sample a region code. The code says whether the sample is an imaging pixel, a light-sensitive border pixel that is not for imaging, a shielded reference pixel, or a site that is unusable as a reference. Downstream logic uses the code to crop the image and to choose clamp sources.

Only shielded reference samples are summed. Sites that read dark but pick up stray charge from their neighbours are left out. So are horizontal-register-only sites that carry nothing but register dark current. Once a complete line has been counted, the block publishes that line's rounded mean reference level. Once a complete frame has been counted, it publishes the rounded mean of the reference rows at the top of the frame. A black-clamp loop uses both values.

Stream order is checked. A line or frame marker that arrives before the previous line or frame is complete restarts the counters. It also latches a sticky error and suppresses the averages that the short line or frame would have produced. Column and row geometry are parameters. With the default values the frame is 3448 positions by 2574 lines, with 3326 by 2504 imaging pixels.

Top module: `ccd_region_tagger`

## Requirements
- R1: While reset is held, and in the first cycle after it: `tag_valid`, `line_dark_valid`, `frame_dark_valid` and `sync_err` are 0, and both means are 0.
- R2: `tag_valid` is 1 in the cycle after a cycle with `pix_valid` high, and 0 in the cycle after a cycle with `pix_valid` low. The tag codes are: active 0, active buffer 1, blue buffer 2, dark reference 3, dark dummy 4, register dummy 5, virtual column 6, test site 7.
- R3: Along a line, starting at column 0, the column classes run in this order: `C_VDUM` virtual, `C_DUM_LEAD` dummy, 1 test, `C_DD_LEAD` dark dummy, `C_BLUE` blue, `C_ABUF` buffer, `C_ACT` active, `C_ABUF` buffer, `C_BLUE` blue, `C_DD_TR1` dark dummy, `C_DARK` dark reference, `C_DD_TR2` dark dummy, 1 test, `C_DUM_TR` dummy.
- R4: Down a frame, starting at row 0, the row classes run in this order: `R_DD_TOP` dark dummy, `R_DARK` dark reference, `R_DD_MID` dark dummy, `R_BLUE` blue, `R_ABUF` buffer, `R_ACT` active, `R_ABUF` buffer, `R_BLUE` blue, `R_DD_BOT` dark dummy.
- R5: Each tag is formed from its row and column classes. A virtual, dummy or test column class wins outright. Otherwise the first of dark dummy, dark reference, blue, buffer that either class holds is used, in that order. If neither class holds any of these, the tag is active.
- R6: `tag_active` is 1 exactly when `tag_valid` is 1 and the tag is 0.
- R7: In the cycle after the last column of a line, `line_dark_valid` pulses and `line_dark_mean` takes round-half-up(sum/`C_DARK`) over the line's dark-reference columns. This happens for every line whose row class is not dark dummy.
- R8: In the cycle after the last pixel of a frame, `frame_dark_valid` pulses and `frame_dark_mean` takes the round-half-up mean of all pixels tagged dark reference in dark-reference rows.
- R9: Samples tagged dark dummy, dummy, virtual or test never change either mean.
- R10: A `line_start` together with a pixel at a column other than 0 does three things. It places that pixel at column 0 of the next row, sets `sync_err`, and suppresses the mean of the cut line and of the current frame.
- R11: A `frame_start` together with a pixel anywhere other than row 0, column 0 places that pixel at row 0, column 0 and sets `sync_err`. The aborted frame gives no frame mean. The restarted frame is averaged normally.
- R12: `sync_err` stays 1 until reset. Both means hold their values between pulses, including through idle cycles.
- R13: The rounded means are exact for every sum, including full-scale samples (mean 65535 for 16-bit data), whether or not the divisor is a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | A sample is presented this cycle |
| line_start | input | 1 | Sample is the first of a line |
| frame_start | input | 1 | Sample is the first of a frame |
| pix_data | input | DW | Sample value |
| tag_valid | output | 1 | Tag outputs describe the previous cycle's sample |
| tag | output | 3 | Region code |
| tag_active | output | 1 | Sample is an imaging pixel |
| line_dark_valid | output | 1 | Line mean updated |
| line_dark_mean | output | DW | Rounded mean of the line's reference columns |
| frame_dark_valid | output | 1 | Frame mean updated |
| frame_dark_mean | output | DW | Rounded mean of the reference rows |
| sync_err | output | 1 | Sticky early-marker flag |

## Verification
A reduced geometry of 22 columns by 12 rows is swept over every pixel position in several frames, and each tag and mean is predicted arithmetically. One frame uses a position-derived ramp with idle gaps, which tests the tag map and the hold behaviour. A second frame sets every excluded site to full scale and the reference sites to small values, so any leak from dummy or dark-dummy sites shows up at once. An all-full-scale frame and a product pattern test the reciprocal rounding at its limits and at uneven remainders. Streams with a line marker cut mid-line and a frame marker cut mid-frame show the restart placement, the suppressed means and the sticky flag, which is then cleared only by a second reset.

// File: rtl/ccdtag_pkg.sv
package ccdtag_pkg;

   typedef enum logic [2:0] {
      RG_ACTIVE = 3'd0,
      RG_ABUF   = 3'd1,
      RG_BLUE   = 3'd2,
      RG_DARK   = 3'd3,
      RG_DDUM   = 3'd4,
      RG_DUMMY  = 3'd5,
      RG_VDUM   = 3'd6,
      RG_TEST   = 3'd7
   } region_t;

   localparam int N_COL_SEG = 14;
   localparam int N_ROW_SEG = 9;

   // Sites that belong to the shift register alone, or to test structures.
   function automatic logic reg_only(region_t r);
      return (r == RG_VDUM) || (r == RG_DUMMY) || (r == RG_TEST);
   endfunction

endpackage

// File: rtl/ccdtag_count.sv
module ccdtag_count #(
   parameter int LINE_PIX    = 3448,
   parameter int FRAME_LINES = 2574,
   localparam int CW = $clog2(LINE_PIX),
   localparam int RW = $clog2(FRAME_LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_valid,
   input  logic          line_start,
   input  logic          frame_start,
   output logic [CW-1:0] cur_col,
   output logic [RW-1:0] cur_row,
   output logic [CW-1:0] col_q,
   output logic          line_last,
   output logic          frame_first,
   output logic          frame_last,
   output logic          frame_ok_now,
   output logic          sync_err
);

   localparam logic [CW-1:0] LAST_COL = CW'(LINE_PIX - 1);
   localparam logic [RW-1:0] LAST_ROW = RW'(FRAME_LINES - 1);

   logic [RW-1:0] row_q;
   logic          fok_q;
   logic          err_q;
   logic          fs_v;
   logic          early_line;
   logic          early_frame;

   function automatic logic [RW-1:0] next_row(input logic [RW-1:0] r);
      return (r == LAST_ROW) ? '0 : r + RW'(1);
   endfunction

   always_comb begin
      fs_v        = pix_valid && frame_start;
      early_frame = fs_v && ((col_q != '0) || (row_q != '0));
      early_line  = pix_valid && line_start && !frame_start && (col_q != '0);
      if (fs_v) begin
         cur_col = '0;
         cur_row = '0;
      end else if (early_line) begin
         cur_col = '0;
         cur_row = next_row(row_q);
      end else begin
         cur_col = col_q;
         cur_row = row_q;
      end
      if (fs_v)            frame_ok_now = 1'b1;
      else if (early_line) frame_ok_now = 1'b0;
      else                 frame_ok_now = fok_q;
      line_last   = (cur_col == LAST_COL);
      frame_last  = line_last && (cur_row == LAST_ROW);
      frame_first = (cur_col == '0) && (cur_row == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
         fok_q <= 1'b1;
         err_q <= 1'b0;
      end else if (pix_valid) begin
         col_q <= line_last ? '0 : cur_col + CW'(1);
         row_q <= line_last ? next_row(cur_row) : cur_row;
         fok_q <= frame_last ? 1'b1 : frame_ok_now;
         if (early_line || early_frame) err_q <= 1'b1;
      end
   end

   assign sync_err = err_q;

endmodule

// File: rtl/ccdtag_region.sv
module ccdtag_region
   import ccdtag_pkg::*;
#(
   parameter int CW = 12,
   parameter int RW = 12,
   parameter int CSEG [N_COL_SEG] = '{4, 13, 1, 5, 4, 16, 3326, 16, 4, 6, 39, 8, 1, 5},
   parameter int RSEG [N_ROW_SEG] = '{6, 12, 8, 4, 16, 2504, 16, 4, 4}
) (
   input  logic [CW-1:0] col,
   input  logic [RW-1:0] row,
   output region_t       col_cls,
   output region_t       row_cls,
   output region_t       tag
);

   localparam region_t CCLS [N_COL_SEG] = '{
      RG_VDUM, RG_DUMMY, RG_TEST, RG_DDUM, RG_BLUE, RG_ABUF, RG_ACTIVE,
      RG_ABUF, RG_BLUE, RG_DDUM, RG_DARK, RG_DDUM, RG_TEST, RG_DUMMY};
   localparam region_t RCLS [N_ROW_SEG] = '{
      RG_DDUM, RG_DARK, RG_DDUM, RG_BLUE, RG_ABUF, RG_ACTIVE,
      RG_ABUF, RG_BLUE, RG_DDUM};

   // Column segment lookup: first segment whose running end exceeds col.
   always_comb begin
      int   bound;
      logic hit;
      bound   = 0;
      hit     = 1'b0;
      col_cls = CCLS[N_COL_SEG-1];
      for (int i = 0; i < N_COL_SEG; i++) begin
         bound = bound + CSEG[i];
         if (!hit && (int'(col) < bound)) begin
            col_cls = CCLS[i];
            hit     = 1'b1;
         end
      end
   end

   always_comb begin
      int   bound;
      logic hit;
      bound   = 0;
      hit     = 1'b0;
      row_cls = RCLS[N_ROW_SEG-1];
      for (int i = 0; i < N_ROW_SEG; i++) begin
         bound = bound + RSEG[i];
         if (!hit && (int'(row) < bound)) begin
            row_cls = RCLS[i];
            hit     = 1'b1;
         end
      end
   end

   // Merge: register-only columns win, then the stronger of the two classes.
   always_comb begin
      if (reg_only(col_cls))                                tag = col_cls;
      else if ((row_cls == RG_DDUM) || (col_cls == RG_DDUM)) tag = RG_DDUM;
      else if ((row_cls == RG_DARK) || (col_cls == RG_DARK)) tag = RG_DARK;
      else if ((row_cls == RG_BLUE) || (col_cls == RG_BLUE)) tag = RG_BLUE;
      else if ((row_cls == RG_ABUF) || (col_cls == RG_ABUF)) tag = RG_ABUF;
      else                                                  tag = RG_ACTIVE;
   end

endmodule

// File: rtl/ccdtag_rdiv.sv
module ccdtag_rdiv #(
   parameter int IN_W = 22,
   parameter int DW   = 16,
   parameter int DIV  = 39
) (
   input  logic [IN_W-1:0] sum,
   output logic [DW-1:0]   q
);

   if (DIV < 1) begin : g_bad_div
      $error("ccdtag_rdiv: divisor must be positive");
   end

   if ((DIV & (DIV - 1)) == 0) begin : g_shift
      localparam int SH = $clog2(DIV);
      if (SH == 0) begin : g_unit
         assign q = DW'(sum);
      end else begin : g_round
         logic [IN_W:0] biased;
         assign biased = {1'b0, sum} + (IN_W+1)'(DIV / 2);
         assign q      = DW'(biased >> SH);
      end
   end else begin : g_recip
      // round(sum/DIV) = floor((2*sum + DIV) / (2*DIV)), done as a multiply.
      localparam int D2  = 2 * DIV;
      localparam int LD  = $clog2(D2);
      localparam int SH  = 2 * LD + DW + 1;
      localparam int XW  = LD + DW + 1;
      localparam logic [63:0] MUL = ((64'd1 << SH) + 64'(D2) - 64'd1) / 64'(D2);
      if (SH > 63) begin : g_bad_range
         $error("ccdtag_rdiv: divisor too large for 64-bit reciprocal");
      end
      logic [XW-1:0]    num;
      logic [XW+63:0]   prod;
      assign num  = XW'({sum, 1'b0}) + XW'(DIV);
      assign prod = (XW+64)'(num) * (XW+64)'(MUL);
      assign q    = DW'(prod >> SH);
   end

endmodule

// File: rtl/ccdtag_mean.sv
module ccdtag_mean #(
   parameter int DW = 16,
   parameter int N  = 39,
   localparam int AW = DW + $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          first,
   input  logic          incl,
   input  logic [DW-1:0] data,
   input  logic          last,
   input  logic          emit,
   output logic [DW-1:0] mean,
   output logic          valid
);

   logic [AW-1:0] acc_q;
   logic [AW-1:0] sum_now;
   logic [DW-1:0] quot;

   assign sum_now = (first ? '0 : acc_q) + (incl ? AW'(data) : '0);

   ccdtag_rdiv #(.IN_W(AW), .DW(DW), .DIV(N)) u_div (
      .sum (sum_now),
      .q   (quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         mean  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= en && last && emit;
         if (en) acc_q <= sum_now;
         if (en && last && emit) mean <= quot;
      end
   end

endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
   import ccdtag_pkg::*;
#(
   parameter int DW         = 16,
   parameter int C_VDUM     = 4,
   parameter int C_DUM_LEAD = 13,
   parameter int C_DD_LEAD  = 5,
   parameter int C_BLUE     = 4,
   parameter int C_ABUF     = 16,
   parameter int C_ACT      = 3326,
   parameter int C_DD_TR1   = 6,
   parameter int C_DARK     = 39,
   parameter int C_DD_TR2   = 8,
   parameter int C_DUM_TR   = 5,
   parameter int R_DD_TOP   = 6,
   parameter int R_DARK     = 12,
   parameter int R_DD_MID   = 8,
   parameter int R_BLUE     = 4,
   parameter int R_ABUF     = 16,
   parameter int R_ACT      = 2504,
   parameter int R_DD_BOT   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_valid,
   input  logic          line_start,
   input  logic          frame_start,
   input  logic [DW-1:0] pix_data,
   output logic          tag_valid,
   output logic [2:0]    tag,
   output logic          tag_active,
   output logic          line_dark_valid,
   output logic [DW-1:0] line_dark_mean,
   output logic          frame_dark_valid,
   output logic [DW-1:0] frame_dark_mean,
   output logic          sync_err
);

   localparam int LINE_PIX = C_VDUM + C_DUM_LEAD + 1 + C_DD_LEAD + 2 * C_BLUE
                           + 2 * C_ABUF + C_ACT + C_DD_TR1 + C_DARK + C_DD_TR2
                           + 1 + C_DUM_TR;
   localparam int FRAME_LINES = R_DD_TOP + R_DARK + R_DD_MID + 2 * R_BLUE
                              + 2 * R_ABUF + R_ACT + R_DD_BOT;
   localparam int CW      = $clog2(LINE_PIX);
   localparam int RW      = $clog2(FRAME_LINES);
   localparam int LINE_N  = C_DARK;
   localparam int FRAME_N = R_DARK * (2 * C_BLUE + 2 * C_ABUF + C_ACT + C_DARK);

   if (C_DARK < 1 || R_DARK < 1) begin : g_bad_ref
      $error("ccd_region_tagger: reference columns and rows must be present");
   end
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("ccd_region_tagger: sample width out of range");
   end
   if (FRAME_LINES < 2) begin : g_bad_rows
      $error("ccd_region_tagger: frame needs at least two lines");
   end

   logic [CW-1:0] cur_col;
   logic [CW-1:0] col_q;
   logic [RW-1:0] cur_row;
   logic          line_last;
   logic          frame_first;
   logic          frame_last;
   logic          frame_ok_now;
   region_t       col_cls;
   region_t       row_cls;
   region_t       tag_now;

   ccdtag_count #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_count (
      .clk          (clk),
      .rst_n        (rst_n),
      .pix_valid    (pix_valid),
      .line_start   (line_start),
      .frame_start  (frame_start),
      .cur_col      (cur_col),
      .cur_row      (cur_row),
      .col_q        (col_q),
      .line_last    (line_last),
      .frame_first  (frame_first),
      .frame_last   (frame_last),
      .frame_ok_now (frame_ok_now),
      .sync_err     (sync_err)
   );

   ccdtag_region #(
      .CW   (CW),
      .RW   (RW),
      .CSEG ('{C_VDUM, C_DUM_LEAD, 1, C_DD_LEAD, C_BLUE, C_ABUF, C_ACT,
               C_ABUF, C_BLUE, C_DD_TR1, C_DARK, C_DD_TR2, 1, C_DUM_TR}),
      .RSEG ('{R_DD_TOP, R_DARK, R_DD_MID, R_BLUE, R_ABUF, R_ACT,
               R_ABUF, R_BLUE, R_DD_BOT})
   ) u_region (
      .col     (cur_col),
      .row     (cur_row),
      .col_cls (col_cls),
      .row_cls (row_cls),
      .tag     (tag_now)
   );

   logic line_incl;
   logic line_emit;
   logic frame_incl;

   assign line_incl  = (tag_now == RG_DARK) && (col_cls == RG_DARK);
   assign line_emit  = (row_cls != RG_DDUM);
   assign frame_incl = (tag_now == RG_DARK) && (row_cls == RG_DARK);

   ccdtag_mean #(.DW(DW), .N(LINE_N)) u_line_mean (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pix_valid),
      .first (cur_col == '0),
      .incl  (line_incl),
      .data  (pix_data),
      .last  (line_last),
      .emit  (line_emit),
      .mean  (line_dark_mean),
      .valid (line_dark_valid)
   );

   ccdtag_mean #(.DW(DW), .N(FRAME_N)) u_frame_mean (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pix_valid),
      .first (frame_first),
      .incl  (frame_incl),
      .data  (pix_data),
      .last  (frame_last),
      .emit  (frame_ok_now),
      .mean  (frame_dark_mean),
      .valid (frame_dark_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_valid  <= 1'b0;
         tag        <= 3'd0;
         tag_active <= 1'b0;
      end else begin
         tag_valid  <= pix_valid;
         tag_active <= pix_valid && (tag_now == RG_ACTIVE);
         if (pix_valid) tag <= tag_now;
      end
   end

endmodule

// File: rtl/ccd_region_tagger_chk.sv
module ccd_region_tagger_chk #(
   parameter int DW = 16,
   parameter int CW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pix_valid,
   input logic          line_start,
   input logic          frame_start,
   input logic          tag_valid,
   input logic [2:0]    tag,
   input logic          tag_active,
   input logic          line_dark_valid,
   input logic [DW-1:0] line_dark_mean,
   input logic          frame_dark_valid,
   input logic          sync_err,
   input logic [CW-1:0] col_q
);

   // R2
   tagv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> tag_valid);

   // R2
   tagv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !tag_valid);

   // R6
   active_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_valid |-> (tag_active == (tag == 3'd0)));

   // R10
   early_line_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && line_start && !frame_start && (col_q != '0)) |=> sync_err);

   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |=> sync_err);

   // R12
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_dark_valid |-> $stable(line_dark_mean));

   // R7
   line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_dark_valid |-> tag_valid);

   // R8
   frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_dark_valid |=> !frame_dark_valid);

endmodule

bind ccd_region_tagger ccd_region_tagger_chk #(.DW(DW), .CW(CW)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .pix_valid        (pix_valid),
   .line_start       (line_start),
   .frame_start      (frame_start),
   .tag_valid        (tag_valid),
   .tag              (tag),
   .tag_active       (tag_active),
   .line_dark_valid  (line_dark_valid),
   .line_dark_mean   (line_dark_mean),
   .frame_dark_valid (frame_dark_valid),
   .sync_err         (sync_err),
   .col_q            (col_q)
);

// File: tb/ccd_region_tagger_tb_top.sv
module ccd_region_tagger_tb_top;

   localparam int NCOL = 22;
   localparam int NROW = 12;
   localparam int NL   = 3;
   localparam int NF   = 26;
   localparam int CS [14] = '{1, 2, 1, 1, 1, 2, 4, 2, 1, 1, 3, 1, 1, 1};
   localparam int CC [14] = '{6, 5, 7, 4, 2, 1, 0, 1, 2, 4, 3, 4, 7, 5};
   localparam int RS [9]  = '{1, 2, 1, 1, 1, 3, 1, 1, 1};
   localparam int RC [9]  = '{4, 3, 4, 2, 1, 0, 1, 2, 4};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic        line_start = 1'b0;
   logic        frame_start = 1'b0;
   logic [15:0] pix_data = '0;
   logic        tag_valid, tag_active, line_dark_valid, frame_dark_valid, sync_err;
   logic [2:0]  tag;
   logic [15:0] line_dark_mean, frame_dark_mean;

   always #10 clk = ~clk;

   ccd_region_tagger #(
      .DW(16), .C_VDUM(1), .C_DUM_LEAD(2), .C_DD_LEAD(1), .C_BLUE(1), .C_ABUF(2),
      .C_ACT(4), .C_DD_TR1(1), .C_DARK(3), .C_DD_TR2(1), .C_DUM_TR(1),
      .R_DD_TOP(1), .R_DARK(2), .R_DD_MID(1), .R_BLUE(1), .R_ABUF(1),
      .R_ACT(3), .R_DD_BOT(1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
      .frame_start(frame_start), .pix_data(pix_data), .tag_valid(tag_valid),
      .tag(tag), .tag_active(tag_active), .line_dark_valid(line_dark_valid),
      .line_dark_mean(line_dark_mean), .frame_dark_valid(frame_dark_valid),
      .frame_dark_mean(frame_dark_mean), .sync_err(sync_err)
   );

   int    n_chk = 0, n_fail = 0, cyc = 0;
   bit    finished = 0;
   string phase = "R7";
   int br, bc, fok, fnum;
   longint lsum, fsum;
   int e_tv, e_tag, e_lv, e_lm, e_fv, e_fm, e_err;

   function automatic int ccls(int c);
      int acc = 0;
      for (int i = 0; i < 14; i++) begin
         acc += CS[i];
         if (c < acc) return CC[i];
      end
      return CC[13];
   endfunction

   function automatic int rcls(int r);
      int acc = 0;
      for (int i = 0; i < 9; i++) begin
         acc += RS[i];
         if (r < acc) return RC[i];
      end
      return RC[8];
   endfunction

   function automatic int exp_tag(int r, int c);
      int cc = ccls(c), rc = rcls(r);
      if (cc >= 5) return cc;
      for (int k = 4; k >= 1; k--) if (rc == k || cc == k) return k;
      return 0;
   endfunction

   function automatic int pattern(int mode, int f, int r, int c, int t);
      case (mode)
         0: return (f * 4099 + r * 257 + c * 31 + 7) & 16'hFFFF;
         1: return (t >= 4) ? 16'hFFFF : ((r * 3 + c) & 255);
         2: return 16'hFFFF;
         default: return ((r * c * 1237) ^ (f << 9) ^ (c * 5)) & 16'hFFFF;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s (phase %s) act=%0d exp=%0d at cycle %0d", req, phase, act, exp, cyc);
      end
   endtask

   task automatic model_reset();
      br = 0; bc = 0; fok = 1; lsum = 0; fsum = 0;
      e_tv = 0; e_tag = 0; e_lv = 0; e_lm = 0; e_fv = 0; e_fm = 0; e_err = 0;
   endtask

   task automatic check_outputs();
      chk("R2 tag_valid", tag_valid, e_tv);
      if (e_tv != 0) begin
         chk("R3 R4 R5 tag", tag, e_tag);
         chk("R6 tag_active", tag_active, (e_tag == 0) ? 1 : 0);
      end
      chk("R7 line_dark_valid", line_dark_valid, e_lv);
      chk("R7 R12 line_dark_mean", line_dark_mean, e_lm);
      chk("R8 frame_dark_valid", frame_dark_valid, e_fv);
      chk("R8 R12 frame_dark_mean", frame_dark_mean, e_fm);
      chk("R10 R11 sync_err", sync_err, e_err);
   endtask

   task automatic idle();
      @(negedge clk);
      check_outputs();
      pix_valid = 0; line_start = 0; frame_start = 0;
      e_tv = 0; e_lv = 0; e_fv = 0;
   endtask

   task automatic pixel(int ls, int fs, int mode);
      int t, d;
      @(negedge clk);
      check_outputs();
      if (fs != 0) begin
         if (br != 0 || bc != 0) e_err = 1;
         br = 0; bc = 0; fok = 1;
      end else if (ls != 0 && bc != 0) begin
         e_err = 1; bc = 0; br = (br == NROW - 1) ? 0 : br + 1; fok = 0;
      end
      t = exp_tag(br, bc);
      d = pattern(mode, fnum, br, bc, t);
      pix_valid = 1; line_start = (ls != 0); frame_start = (fs != 0);
      pix_data = d[15:0];
      if (bc == 0) lsum = 0;
      if (br == 0 && bc == 0) fsum = 0;
      if (t == 3 && ccls(bc) == 3) lsum += d;
      if (t == 3 && rcls(br) == 3) fsum += d;
      e_tv = 1; e_tag = t;
      e_lv = (bc == NCOL - 1 && rcls(br) != 4) ? 1 : 0;
      if (e_lv != 0) e_lm = int'((2 * lsum + NL) / (2 * NL));
      e_fv = (bc == NCOL - 1 && br == NROW - 1 && fok != 0) ? 1 : 0;
      if (e_fv != 0) e_fm = int'((2 * fsum + NF) / (2 * NF));
      if (bc == NCOL - 1) begin
         bc = 0;
         if (br == NROW - 1) begin
            br = 0; fok = 1; fnum++;
         end else br++;
      end else bc++;
   endtask

   task automatic stream(int n, int mode, int gaps);
      for (int k = 0; k < n; k++) begin
         if (gaps != 0 && (k % 7) == 3) idle();
         pixel(bc == 0 ? 1 : 0, (bc == 0 && br == 0) ? 1 : 0, mode);
      end
   endtask

   function automatic int remaining();
      return (NROW - 1 - br) * NCOL + (NCOL - bc);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; pix_valid = 0; line_start = 0; frame_start = 0;
      model_reset();
      repeat (2) begin
         @(negedge clk);
         chk("R1 reset tag_valid", tag_valid, 0);
         chk("R1 reset line_dark_valid", line_dark_valid, 0);
         chk("R1 reset frame_dark_valid", frame_dark_valid, 0);
         chk("R1 reset line_dark_mean", line_dark_mean, 0);
         chk("R1 reset frame_dark_mean", frame_dark_mean, 0);
         chk("R1 R12 reset sync_err", sync_err, 0);
      end
      rst_n = 1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      fnum = 0;
      model_reset();
      do_reset();
      idle();
      phase = "R7 R8";
      stream(NROW * NCOL, 0, 1);
      idle();
      phase = "R9";
      stream(NROW * NCOL, 1, 0);
      idle();
      phase = "R13";
      stream(NROW * NCOL, 2, 0);
      stream(NROW * NCOL, 3, 1);
      idle(); idle();
      phase = "R10";
      stream(6 * NCOL + 10, 0, 0);
      pixel(1, 0, 0);
      stream(remaining(), 0, 0);
      idle();
      phase = "R11";
      stream(3 * NCOL + 5, 3, 0);
      pixel(1, 1, 3);
      stream(remaining(), 3, 0);
      idle(); idle();
      phase = "R12";
      stream(NROW * NCOL, 1, 1);
      idle();
      chk("R12 sync_err still set", sync_err, 1);
      do_reset();
      phase = "R1";
      idle();
      stream(NROW * NCOL, 0, 0);
      idle(); idle();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule